// File: doc/BRIEF.md
# SPI Master with Lead, Shift, Trail and Idle Phases

This block is a serial peripheral interface controller that drives the serial clock, one chip-select line and the data-out line, and samples the data-in line. Each data element is sent and received at the same time. Each element is framed by a phase sequencer. A lead phase separates the chip-select assertion from the first clock edge. A trail phase follows the last clock edge. An idle phase keeps chip select released before a new frame may start. The three phase lengths count in half-periods of the serial clock.

Elements arrive through a valid/ready handshake. Each received element is presented with a one-cycle valid strobe. An optional parity bit can be appended, with either even or odd sense, and a one-cycle error pulse flags a received parity mismatch. In single-transfer mode, chip select is released after every element. In continuous mode, chip select stays asserted while elements keep arriving in time.

The configuration inputs must be held stable while chip select is asserted and until the idle phase has ended.

Top module: `spim_master`

## Requirements
- R1: After synchronous reset, chip select is inactive, sclk sits at the level of cfg_cpol, tx_ready is 1, and rx_valid and par_err are 0.
- R2: Outside a frame, sclk rests at cfg_cpol. Each element produces exactly 2N sclk edges, where N = DATA_W + cfg_par_en, and sclk is back at cfg_cpol when chip select is released.
- R3: Edges of an element are numbered from 0. With cfg_cpha=0, SDI is sampled on even-numbered edges and SDO changes on odd-numbered edges. With cfg_cpha=1, SDO changes on even-numbered edges other than edge 0, and SDI is sampled on odd-numbered edges.
- R4: With cfg_lsb_first=0, bit DATA_W-1 travels first. With cfg_lsb_first=1, bit 0 travels first. The same order applies on SDO and on SDI, and rx_data is reassembled to the original bit weights.
- R5: When cfg_par_en=1, one parity bit follows the data bits on SDO. With cfg_par_odd=0 (even), the data bits plus the parity bit hold an even number of ones. With cfg_par_odd=1 (odd), they hold an odd number of ones.
- R6: par_err pulses for one cycle, together with rx_valid, when cfg_par_en=1 and the received data bits plus the received parity bit break the selected sense. Otherwise par_err stays 0.
- R7: rx_valid is a single-cycle pulse, raised once per element, and rx_data holds the DATA_W bits sampled from SDI.
- R8: The first sclk edge after chip select asserts comes exactly max(cfg_lead,1)·(cfg_div+1) clock cycles later.
- R9: Chip select is released exactly max(cfg_trail,1)·(cfg_div+1) clock cycles after the last sclk edge of a frame.
- R10: After release, chip select stays inactive for at least max(cfg_idle,1)·(cfg_div+1) clock cycles.
- R11: With cfg_cont=0, every chip-select window carries exactly one element.
- R12: With cfg_cont=1, an element that is valid when the trail phase ends is sent without releasing chip select. Its first edge comes (max(cfg_trail,1)+1)·(cfg_div+1) cycles after the previous last edge. If no element is valid then, chip select is released.
- R13: With cfg_cs_high=1, chip select is active high. With cfg_cs_high=0, it is active low.
- R14: An element is taken on a cycle where tx_valid and tx_ready are both 1. tx_ready is high only while no frame is running, or in the final cycle of a trail phase in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | DIV_W | sclk half-period minus one, in clock cycles |
| cfg_cpol | input | 1 | sclk idle level |
| cfg_cpha | input | 1 | Sampling edge select (0 = leading, 1 = trailing) |
| cfg_lsb_first | input | 1 | 1 = bit 0 first, 0 = top bit first |
| cfg_par_en | input | 1 | Append and check a parity bit |
| cfg_par_odd | input | 1 | Parity sense (0 = even, 1 = odd) |
| cfg_cs_high | input | 1 | Chip-select active level (1 = high) |
| cfg_cont | input | 1 | 1 = continuous mode, 0 = single-transfer mode |
| cfg_lead | input | DLY_W | Lead phase length in half-periods (0 acts as 1) |
| cfg_trail | input | DLY_W | Trail phase length in half-periods (0 acts as 1) |
| cfg_idle | input | DLY_W | Idle phase length in half-periods (0 acts as 1) |
| tx_data | input | DATA_W | Element to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Element is taken this cycle if tx_valid is 1 |
| rx_data | output | DATA_W | Received element |
| rx_valid | output | 1 | rx_data is new (one-cycle pulse) |
| par_err | output | 1 | Received parity mismatch (one-cycle pulse) |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
The bench targets the following corner cases:

- Zero-valued phase delays with a divider of one clock. A design that treated zero as no phase at all would put the first clock edge directly on the chip-select edge, and the lead timing check would catch it.
- Both clock phases and both bit orders. A slave model captures SDO only on the sampling edges and feeds back a known response, so a swapped edge role or a reversed order corrupts either the captured or the received element.
- Corrupted parity bits under both senses. A wrong sense or a missing check would raise par_err on good data or stay silent on bad data.
- A continuous burst of three elements followed by a lone element. A sequencer that dropped chip select between elements, inserted a full lead phase, or kept chip select asserted with nothing queued would break the element-per-window count or the edge-to-edge gap.

// File: rtl/spim_pkg.sv
// Package: shared types of the SPI master.
// Holds the frame phase encoding used by the sequencer and the top level.
package spim_pkg;

    // Frame phases: no frame, lead, bit shifting, trail and idle.
    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_LEAD  = 3'd1,
        PH_SHIFT = 3'd2,
        PH_TRAIL = 3'd3,
        PH_IDLE  = 3'd4
    } spim_phase_e;

endpackage

// File: rtl/spim_tick.sv
// Module: spim_tick
// Divides the system clock into serial-clock half-periods. It emits one tick
// every (div+1) cycles while run is high. While run is low, the count is
// cleared, so the first tick after run rises always comes div+1 cycles later.
// Assumes div is stable while run is high.
module spim_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Half-period counter, held at zero whenever no frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spim_seq.sv
// Module: spim_seq
// Frame phase sequencer. It owns chip select and the serial clock level. It
// runs lead, shift, trail and idle phases, and counts sclk edges within an
// element. In continuous mode, an element taken at the end of a trail phase
// gets a single half-period of setup instead of a full lead phase.
// Assumes the configuration is stable while a frame runs, and DATA_W >= 2.
module spim_seq
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 4,
    parameter int EW     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tx_valid,
    input  logic             cfg_cont,
    input  logic             cfg_cpol,
    input  logic             cfg_par_en,
    input  logic [DLY_W-1:0] cfg_lead,
    input  logic [DLY_W-1:0] cfg_trail,
    input  logic [DLY_W-1:0] cfg_idle,
    output spim_phase_e      phase,
    output logic             tx_ready,
    output logic             load,
    output logic             edge_now,
    output logic [EW-1:0]    edge_idx,
    output logic             last_edge,
    output logic             cs_act,
    output logic             sclk_q
);

    localparam logic [EW-1:0] LAST_PLAIN = EW'(2 * DATA_W - 1);
    localparam logic [EW-1:0] LAST_PAR   = EW'(2 * DATA_W + 1);

    logic [DLY_W-1:0] pcnt;
    logic [DLY_W-1:0] dsel;
    logic [DLY_W-1:0] lim_m1;
    logic             ph_last;
    logic             burst;
    logic [EW-1:0]    last_idx;

    // Select the length of the running phase; zero acts as one half-period.
    always_comb begin
        unique case (phase)
            PH_LEAD:  dsel = burst ? '0 : cfg_lead;
            PH_TRAIL: dsel = cfg_trail;
            PH_IDLE:  dsel = cfg_idle;
            default:  dsel = '0;
        endcase
        lim_m1 = (dsel == '0) ? '0 : dsel - 1'b1;
    end

    assign ph_last   = tick && (pcnt == lim_m1);
    assign last_idx  = cfg_par_en ? LAST_PAR : LAST_PLAIN;
    assign tx_ready  = (phase == PH_OFF) || (phase == PH_TRAIL && ph_last && cfg_cont);
    assign load      = tx_valid && tx_ready;
    assign edge_now  = tick && ((phase == PH_LEAD && ph_last) || phase == PH_SHIFT);
    assign last_edge = edge_now && (edge_idx == last_idx);
    assign edge_idx  = ecnt;

    logic [EW-1:0] ecnt;

    // Phase state, phase counter, edge counter, chip select and sclk level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_OFF;
            pcnt   <= '0;
            ecnt   <= '0;
            cs_act <= 1'b0;
            sclk_q <= 1'b0;
            burst  <= 1'b0;
        end else begin
            if (edge_now) begin
                sclk_q <= ~sclk_q;
                ecnt   <= ecnt + 1'b1;
            end
            unique case (phase)
                PH_OFF: begin
                    sclk_q <= cfg_cpol;
                    pcnt   <= '0;
                    ecnt   <= '0;
                    if (tx_valid) begin
                        phase  <= PH_LEAD;
                        cs_act <= 1'b1;
                        burst  <= 1'b0;
                    end
                end
                PH_LEAD: begin
                    if (tick) begin
                        if (ph_last) begin
                            phase <= PH_SHIFT;
                            pcnt  <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (last_edge) begin
                        phase <= PH_TRAIL;
                        pcnt  <= '0;
                    end
                end
                PH_TRAIL: begin
                    if (tick) begin
                        if (ph_last) begin
                            pcnt <= '0;
                            if (load) begin
                                phase <= PH_LEAD;
                                burst <= 1'b1;
                                ecnt  <= '0;
                            end else begin
                                phase  <= PH_IDLE;
                                cs_act <= 1'b0;
                            end
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
                PH_IDLE: begin
                    if (tick) begin
                        if (ph_last) begin
                            phase <= PH_OFF;
                            pcnt  <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_OFF;
            endcase
        end
    end

    // R14: elements are only offered the ready state when no frame runs or in continuous trail
    a_r14_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (phase == PH_OFF || (phase == PH_TRAIL && cfg_cont)));

    // R12: chip select is held whenever lead or shift is running
    a_r12_cs_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LEAD || phase == PH_SHIFT) |-> cs_act);

    // R10: the idle phase always runs with chip select released
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !cs_act);

    // R2: no clock edge is produced in trail or idle
    a_r2_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRAIL || phase == PH_IDLE) |=> $stable(sclk_q));

endmodule

// File: rtl/spim_shreg.sv
// Module: spim_shreg
// Transmit and receive shift registers with parity. On load, it arranges the
// element in wire order and appends the parity bit. It shifts SDO and samples
// SDI on the edges chosen by the phase setting. After the last edge, it
// reassembles the received element and checks its parity.
// Assumes edge_idx counts sclk edges of the current element from zero.
module spim_shreg #(
    parameter int DATA_W = 8,
    parameter int EW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              edge_now,
    input  logic [EW-1:0]     edge_idx,
    input  logic              last_edge,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              par_err
);

    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0]   txq;
    logic [SR_W-1:0]   rxq;
    logic [SR_W-1:0]   rx_next;
    logic [DATA_W-1:0] raw;
    logic              do_sample;
    logic              do_shift;

    // Mirror the bit order of an element.
    function automatic logic [DATA_W-1:0] flip_bits(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    // Edge roles: the phase setting picks which edges sample and which shift.
    always_comb begin
        if (cfg_cpha) begin
            do_sample = edge_now && edge_idx[0];
            do_shift  = edge_now && !edge_idx[0] && (edge_idx != '0);
        end else begin
            do_sample = edge_now && !edge_idx[0];
            do_shift  = edge_now && edge_idx[0] && !last_edge;
        end
        rx_next = do_sample ? {rxq[SR_W-2:0], sdi} : rxq;
        raw     = cfg_par_en ? rx_next[SR_W-1:1] : rx_next[SR_W-2:0];
    end

    assign sdo = txq[SR_W-1];

    // Transmit register: load in wire order with parity, shift toward the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txq <= '0;
        end else if (load) begin
            txq <= {(cfg_lsb_first ? flip_bits(tx_data) : tx_data), (^tx_data) ^ cfg_par_odd};
        end else if (do_shift) begin
            txq <= {txq[SR_W-2:0], 1'b0};
        end
    end

    // Receive register and result: collect samples, publish on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxq      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            rxq      <= rx_next;
            rx_valid <= last_edge;
            par_err  <= last_edge && cfg_par_en && ((^rx_next) != cfg_par_odd);
            if (last_edge) begin
                rx_data <= cfg_lsb_first ? flip_bits(raw) : raw;
            end
        end
    end

    // R7: a received element is flagged for a single cycle only
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: a parity error is only reported alongside a received element
    a_r6_err_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rx_valid);

    // R3: sampling and shifting never share an edge
    a_r3_roles_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_sample && do_shift));

endmodule

// File: rtl/spim_master.sv
// Module: spim_master
// Top level of the SPI master. It ties the half-period divider, the frame
// phase sequencer and the shift/parity datapath together, and maps the
// internal chip-select state onto the configured active level.
// Assumes the configuration is held while a frame is running.
module spim_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_cs_high,
    input  logic              cfg_cont,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_trail,
    input  logic [DLY_W-1:0]  cfg_idle,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              par_err,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    output logic              cs_o
);

    localparam int EW = $clog2(2 * DATA_W + 2);

    spim_phase_e   phase;
    logic          tick;
    logic          load;
    logic          edge_now;
    logic [EW-1:0] edge_idx;
    logic          last_edge;
    logic          cs_act;
    logic          sclk_q;

    spim_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase != PH_OFF),
        .div   (cfg_div),
        .tick  (tick)
    );

    spim_seq #(.DATA_W(DATA_W), .DLY_W(DLY_W), .EW(EW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_valid   (tx_valid),
        .cfg_cont   (cfg_cont),
        .cfg_cpol   (cfg_cpol),
        .cfg_par_en (cfg_par_en),
        .cfg_lead   (cfg_lead),
        .cfg_trail  (cfg_trail),
        .cfg_idle   (cfg_idle),
        .phase      (phase),
        .tx_ready   (tx_ready),
        .load       (load),
        .edge_now   (edge_now),
        .edge_idx   (edge_idx),
        .last_edge  (last_edge),
        .cs_act     (cs_act),
        .sclk_q     (sclk_q)
    );

    spim_shreg #(.DATA_W(DATA_W), .EW(EW)) u_shreg (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .tx_data       (tx_data),
        .edge_now      (edge_now),
        .edge_idx      (edge_idx),
        .last_edge     (last_edge),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .sdi           (sdi),
        .sdo           (sdo),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .par_err       (par_err)
    );

    assign sclk = sclk_q;
    assign cs_o = cfg_cs_high ? cs_act : ~cs_act;

    // R11: in single-transfer mode, a released chip select follows every received element
    a_r11_release_after_element: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_cont) |-> !tx_ready);

endmodule

// File: tb/spim_master_test.sv
// Bench for spim_master: driver task feeds a scoreboard, a slave model and
// monitors compare wire bits, received elements and phase timing.
module spim_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   cfg_div = 8'd1;
    logic         cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
    logic         cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_cs_high = 1'b0, cfg_cont = 1'b0;
    logic [3:0]   cfg_lead = 4'd1, cfg_trail = 4'd1, cfg_idle = 4'd1;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic [W-1:0] rx_data;
    logic         rx_valid, par_err, sclk, sdo, cs_o;
    logic         sdi;

    spim_master #(.DATA_W(W), .DIV_W(8), .DLY_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_cs_high(cfg_cs_high), .cfg_cont(cfg_cont), .cfg_lead(cfg_lead),
        .cfg_trail(cfg_trail), .cfg_idle(cfg_idle), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_o(cs_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [W-1:0] d; bit flip; } resp_t;
    typedef struct { logic [W-1:0] d; bit perr; } exp_t;

    logic [W-1:0] mosi_q[$];
    resp_t        slv_q[$];
    exp_t         rx_q[$];
    int n_checks = 0, n_fail = 0;
    int exp_elems = 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff(input logic [3:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    function automatic int hp();
        return int'(cfg_div) + 1;
    endfunction

    function automatic int nbits();
        return W + int'(cfg_par_en);
    endfunction

    // Wire-order bit k of an element, parity last, optionally corrupted
    function automatic logic wire_bit(input logic [W-1:0] d, input int k, input bit flip);
        if (k < W) return cfg_lsb ? d[k] : d[W-1-k];
        return (^d) ^ cfg_par_odd ^ flip;
    endfunction

    function automatic bit cs_active();
        return cs_o == cfg_cs_high;
    endfunction

    // Driver: records expectations, then offers the element until taken (R14)
    task automatic send(input logic [W-1:0] txd, input logic [W-1:0] rsd, input bit flip);
        resp_t r;
        exp_t  e;
        r.d = rsd; r.flip = flip;
        e.d = rsd; e.perr = cfg_par_en && flip;
        mosi_q.push_back(txd);
        slv_q.push_back(r);
        rx_q.push_back(e);
        tx_data  = txd;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic drain();
        while (rx_q.size() != 0 || cs_active()) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    task automatic idle_levels();
        repeat (4) @(negedge clk);
        check(sclk == cfg_cpol, "R2", "sclk idle level", sclk, cfg_cpol);
        check(cs_o == !cfg_cs_high, "R13", "chip select idle level", cs_o, !cfg_cs_high);
    endtask

    // Slave model: captures SDO on sampling edges, drives SDI on shifting edges (R3, R4, R5)
    resp_t        cur;
    bit           have_cur;
    int           ecount;
    logic         s_sclk_prev;
    logic [W:0]   mosi_bits;
    always @(negedge clk) begin
        if (!rst_n) begin
            have_cur    = 0;
            ecount      = 0;
            sdi         = 1'b0;
            s_sclk_prev = sclk;
        end else begin
            if (have_cur && cs_active() && sclk !== s_sclk_prev) begin
                int e;
                e = ecount;
                if (cfg_cpha ? e[0] : !e[0]) mosi_bits[e/2] = sdo;
                ecount++;
                if (!cfg_cpha && e[0] && ((e + 1) / 2) < nbits()) sdi = wire_bit(cur.d, (e + 1) / 2, cur.flip);
                if (cfg_cpha && !e[0]) sdi = wire_bit(cur.d, e / 2, cur.flip);
                if (ecount == 2 * nbits()) begin
                    logic [W-1:0] txd;
                    logic [W:0]   expv;
                    logic [W:0]   actv;
                    txd  = mosi_q.pop_front();
                    expv = '0;
                    actv = '0;
                    for (int k = 0; k < nbits(); k++) begin
                        expv[k] = wire_bit(txd, k, 1'b0);
                        actv[k] = mosi_bits[k];
                    end
                    check(actv == expv, "R4", "SDO wire bits (R3 edges, R5 parity)", int'(actv), int'(expv));
                    have_cur = 0;
                end
            end
            s_sclk_prev = sclk;
            if (cs_active() && !have_cur && slv_q.size() > 0) begin
                cur      = slv_q.pop_front();
                have_cur = 1;
                ecount   = 0;
                sdi      = wire_bit(cur.d, 0, cur.flip);
            end
        end
    end

    // Timing monitor: lead, trail, idle, edge counts and elements per window
    int   cyc = 0, t_on = 0, t_last = 0, t_off = -1, m_edges = 0, m_elems = 0;
    logic m_cs_prev = 1'b0, m_sclk_prev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cs_prev   = 1'b0;
            m_sclk_prev = sclk;
            t_off       = -1;
        end else begin
            if (cs_active() && !m_cs_prev) begin
                if (t_off >= 0)
                    check(cyc - t_off >= eff(cfg_idle) * hp(), "R10", "idle gap cycles", cyc - t_off, eff(cfg_idle) * hp());
                t_on = cyc; m_edges = 0; m_elems = 0;
            end
            if (cs_active() && m_cs_prev && sclk !== m_sclk_prev) begin
                if (m_edges == 0) begin
                    if (m_elems == 0)
                        check(cyc - t_on == eff(cfg_lead) * hp(), "R8", "lead cycles", cyc - t_on, eff(cfg_lead) * hp());
                    else
                        check(cyc - t_last == (eff(cfg_trail) + 1) * hp(), "R12", "element gap cycles",
                              cyc - t_last, (eff(cfg_trail) + 1) * hp());
                end
                t_last = cyc;
                m_edges++;
                if (m_edges == 2 * nbits()) begin
                    m_edges = 0;
                    m_elems++;
                end
            end
            if (!cs_active() && m_cs_prev) begin
                check(cyc - t_last == eff(cfg_trail) * hp(), "R9", "trail cycles", cyc - t_last, eff(cfg_trail) * hp());
                check(m_edges == 0, "R2", "leftover edges", m_edges, 0);
                check(sclk == cfg_cpol, "R2", "sclk level at release", sclk, cfg_cpol);
                check(m_elems == exp_elems, cfg_cont ? "R12" : "R11", "elements per window", m_elems, exp_elems);
                t_off = cyc;
            end
            m_cs_prev   = cs_active();
            m_sclk_prev = sclk;
        end
    end

    // Scoreboard monitor: received elements and parity flags (R6, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (rx_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected rx_valid", int'(rx_data), 0);
                end else begin
                    exp_t e;
                    e = rx_q.pop_front();
                    check(rx_data == e.d, "R7", "rx_data (R4 order)", int'(rx_data), int'(e.d));
                    check(par_err == e.perr, "R6", "par_err", par_err, e.perr);
                end
            end else if (par_err) begin
                check(1'b0, "R6", "par_err without rx_valid", 1, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R14 watchdog expired: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cs_o == 1'b1, "R1", "cs_o after reset", cs_o, 1);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
        check(rx_valid == 1'b0 && par_err == 1'b0, "R1", "rx_valid/par_err after reset", {rx_valid, par_err}, 0);

        // Mode 0, top bit first, no parity, single-transfer (R11)
        cfg_div = 8'd1; cfg_lead = 4'd2; cfg_trail = 4'd1; cfg_idle = 4'd3;
        exp_elems = 1;
        idle_levels();
        send(8'hA5, 8'h3C, 0);
        send(8'h0F, 8'hC3, 0);
        drain();

        // Clock idle high, sample on trailing edge, bit 0 first
        cfg_cpol = 1; cfg_cpha = 1; cfg_lsb = 1; cfg_div = 8'd2;
        cfg_lead = 4'd1; cfg_trail = 4'd2; cfg_idle = 4'd0;
        idle_levels();
        send(8'h81, 8'h7E, 0);
        send(8'h96, 8'h01, 0);
        drain();

        // Even parity, zero delays, fastest divider; second element has corrupted parity (R5, R6)
        cfg_cpol = 1; cfg_cpha = 0; cfg_lsb = 0; cfg_div = 8'd0;
        cfg_par_en = 1; cfg_par_odd = 0;
        cfg_lead = 4'd0; cfg_trail = 4'd0; cfg_idle = 4'd0;
        idle_levels();
        send(8'h55, 8'hAA, 0);
        send(8'h13, 8'hEE, 1);
        drain();

        // Odd parity with trailing-edge sampling and bit 0 first
        cfg_cpol = 0; cfg_cpha = 1; cfg_lsb = 1; cfg_div = 8'd1; cfg_par_odd = 1;
        cfg_lead = 4'd3; cfg_trail = 4'd1; cfg_idle = 4'd2;
        idle_levels();
        send(8'h00, 8'hFF, 1);
        send(8'h7F, 8'h80, 0);
        drain();

        // Continuous burst of three with active-high chip select (R12, R13)
        cfg_cpol = 0; cfg_cpha = 0; cfg_lsb = 0; cfg_par_odd = 0; cfg_par_en = 1;
        cfg_cont = 1; cfg_cs_high = 1; cfg_div = 8'd1;
        cfg_lead = 4'd3; cfg_trail = 4'd2; cfg_idle = 4'd1;
        exp_elems = 3;
        idle_levels();
        send(8'h12, 8'h34, 0);
        send(8'h56, 8'h78, 0);
        send(8'h9A, 8'hBC, 1);
        drain();

        // Continuous mode with nothing queued: window closes after one element (R12)
        exp_elems = 1;
        send(8'hE7, 8'h5A, 0);
        drain();

        // Active-high chip select in single-transfer mode, slower divider
        cfg_cont = 0; cfg_par_en = 0; cfg_div = 8'd3;
        cfg_lead = 4'd1; cfg_trail = 4'd3; cfg_idle = 4'd4;
        idle_levels();
        send(8'hC0, 8'h03, 0);
        send(8'h3F, 8'hFC, 0);
        drain();

        check(mosi_q.size() == 0 && slv_q.size() == 0, "R7", "leftover expectations",
              mosi_q.size() + slv_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule